// File: doc/BRIEF.md
# Hysteretic Current-Mode Full-Bridge Sequencer

This block turns two comparator levels into the four gate commands of a full bridge. One comparator reports that the sensed inductor current has reached its upper threshold. The other reports that it has reached its lower threshold. The bridge alternates between two diagonal pairs. The rising pair is high-side 1 with low-side 2, and it drives the current up. The falling pair is high-side 2 with low-side 1, and it drives the current down. Each accepted comparator event ends the present interval, turns every gate off for a dead time, and then turns the other pair on.

The dead time depends on the edge and on the conduction mode. An upper-threshold edge always uses the long resonant value. A lower-threshold edge uses a second resonant value in boundary mode and a short minimum value in continuous mode. The dead-time values arrive as 6-bit counts of 7 ns clock cycles from outside logic.

An on-time blanking window keeps each pair on for a minimum number of cycles. This masks commutation ringing and caps the switching rate at the configured maximum. With the default parameters (7000 ps clock, 500 kHz cap) the window is 143 cycles. When the enable is low, every gate is held off. The first pair turned on after enable is chosen by the sign of the current reference.

Top module: `hcm_bridge_seq`

## Requirements
- R1: During reset, and in every cycle after a cycle in which `en` was sampled low, all four gate outputs are 0. Comparator activity has no effect while `en` is low.
- R2: Writing the gates as {hs1_on, ls1_on, hs2_on, ls2_on}, the outputs only ever show 4'b0000, 4'b1001 (rising pair) or 4'b0110 (falling pair). A change from one pair to the other always passes through 4'b0000.
- R3: When `en` is sampled high while the block is off, the next cycle shows the rising pair if `ref_neg` is 0 and the falling pair if `ref_neg` is 1.
- R4: During the rising pair only `cmp_peak` can end the interval, and `cmp_valley` is ignored. During the falling pair only `cmp_valley` can end it, and `cmp_peak` is ignored. Without the matching event, the pair stays on.
- R5: An accepted `cmp_peak` event gives exactly `dt_peak` cycles of 4'b0000, followed by the falling pair. This holds in both modes.
- R6: An accepted `cmp_valley` event with `ccm_mode` = 0 gives exactly `dt_valley_bcm` off cycles, followed by the rising pair.
- R7: An accepted `cmp_valley` event with `ccm_mode` = 1 gives exactly `dt_valley_ccm` off cycles, followed by the rising pair.
- R8: The mode and the dead-time inputs are taken in the cycle the event is accepted. Changing them during the off gap does not alter its length.
- R9: A selected dead-time value of 0 gives one off cycle.
- R10: Every pair stays on for at least MIN_ON_CYC cycles, where MIN_ON_CYC = ceil(10^9 / FSW_MAX_KHZ / 2 / CLK_PS) (143 by default). If the matching comparator is held high from the start of an interval, the interval lasts exactly MIN_ON_CYC cycles.
- R11: `en` sampled low takes priority over a comparator event accepted in the same cycle. The block goes straight to the off state, and no dead-time sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one dead-time step per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low forces all gates off |
| ccm_mode | input | 1 | 1 = continuous conduction, 0 = boundary conduction |
| ref_neg | input | 1 | Sign of current reference; selects first pair after enable |
| cmp_peak | input | 1 | Upper-threshold comparator level |
| cmp_valley | input | 1 | Lower-threshold comparator level |
| dt_peak | input | DT_W | Off cycles after an upper-threshold edge |
| dt_valley_bcm | input | DT_W | Off cycles after a lower-threshold edge, boundary mode |
| dt_valley_ccm | input | DT_W | Off cycles after a lower-threshold edge, continuous mode |
| hs1_on | output | 1 | High-side switch 1 gate |
| ls1_on | output | 1 | Low-side switch 1 gate |
| hs2_on | output | 1 | High-side switch 2 gate |
| ls2_on | output | 1 | Low-side switch 2 gate |

## Verification
A one-cycle enable drop can land in the same cycle as an accepted upper-threshold event. In that cycle the shutdown path and the dead-time path both want the next state. The bench provokes this by raising `cmp_peak` and lowering `en` at the same moment, after the blanking window has run out, and then restoring `en` one cycle later. The correct result is the rising pair reappearing on the next cycle. A design that lets the edge win shows a dead gap followed by the falling pair instead. A second overlap is a comparator held high into the last blanked cycle. There the bench checks that the interval ends on exactly cycle 143 and not one cycle early or late.

// File: rtl/hcm_pkg.sv
// Shared types for the hysteretic bridge sequencer.
// Assumes a single clock domain and synchronous comparator inputs.
package hcm_pkg;

    typedef enum logic [2:0] {
        ST_OFF          = 3'd0,
        ST_RISE         = 3'd1,
        ST_DEAD_TO_FALL = 3'd2,
        ST_FALL         = 3'd3,
        ST_DEAD_TO_RISE = 3'd4
    } seq_state_t;

    typedef enum logic {
        EDGE_PEAK   = 1'b0,
        EDGE_VALLEY = 1'b1
    } edge_kind_t;

endpackage

// File: rtl/hcm_ontime_blank.sv
// Minimum on-time timer: counts cycles while a pair conducts and reports
// when the comparator may be honoured. Assumes run drops for at least one
// cycle between intervals (the dead gap), which restarts the count.
module hcm_ontime_blank #(
    parameter int MIN_ON = 143
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ready
);
    localparam int CW = $clog2(MIN_ON + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_ON - 1);

    logic [CW-1:0] cnt;

    // Count conducting cycles, saturating at the last blanked cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt < LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = run && (cnt >= LAST);

endmodule

// File: rtl/hcm_dt_select.sv
// Dead-time selector: picks the gap length from the edge kind and the
// conduction mode, and lifts a zero value to one cycle.
module hcm_dt_select
    import hcm_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  edge_kind_t      edge_kind,
    input  logic            ccm_mode,
    input  logic [DT_W-1:0] dt_peak,
    input  logic [DT_W-1:0] dt_valley_bcm,
    input  logic [DT_W-1:0] dt_valley_ccm,
    output logic [DT_W-1:0] dt_sel
);
    logic [DT_W-1:0] raw;

    // Peak edge keeps the long value; valley edge depends on mode.
    always_comb begin
        if (edge_kind == EDGE_PEAK) begin
            raw = dt_peak;
        end else if (ccm_mode) begin
            raw = dt_valley_ccm;
        end else begin
            raw = dt_valley_bcm;
        end
        dt_sel = (raw == '0) ? DT_W'(1) : raw;
    end

endmodule

// File: rtl/hcm_dead_timer.sv
// Dead-gap down-counter: loaded on the cycle an edge is accepted, reports
// expiry in the last off cycle. Assumes load values are never zero.
module hcm_dead_timer #(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DT_W-1:0] load_val,
    output logic            expired
);
    logic [DT_W-1:0] cnt;

    // Load on an accepted edge, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == DT_W'(1));

endmodule

// File: rtl/hcm_bridge_seq.sv
// Hysteretic current-mode full-bridge sequencer. Alternates the two diagonal
// pairs on comparator events, with a mode- and edge-dependent dead gap and a
// minimum on-time. Assumes comparator inputs are already synchronous to clk.
module hcm_bridge_seq
    import hcm_pkg::*;
#(
    parameter int DT_W        = 6,
    parameter int CLK_PS      = 7000,
    parameter int FSW_MAX_KHZ = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            ccm_mode,
    input  logic            ref_neg,
    input  logic            cmp_peak,
    input  logic            cmp_valley,
    input  logic [DT_W-1:0] dt_peak,
    input  logic [DT_W-1:0] dt_valley_bcm,
    input  logic [DT_W-1:0] dt_valley_ccm,
    output logic            hs1_on,
    output logic            ls1_on,
    output logic            hs2_on,
    output logic            ls2_on
);
    localparam int HALF_PERIOD_PS = (1_000_000_000 / FSW_MAX_KHZ) / 2;
    localparam int MIN_ON_CYC     = (HALF_PERIOD_PS + CLK_PS - 1) / CLK_PS;

    seq_state_t      state, state_nxt;
    edge_kind_t      edge_kind;
    logic            dt_load;
    logic            blank_ready;
    logic            gap_done;
    logic [DT_W-1:0] dt_sel;
    logic            conducting;

    assign conducting = (state == ST_RISE) || (state == ST_FALL);

    hcm_ontime_blank #(
        .MIN_ON (MIN_ON_CYC)
    ) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (conducting),
        .ready (blank_ready)
    );

    hcm_dt_select #(
        .DT_W (DT_W)
    ) u_dtsel (
        .edge_kind     (edge_kind),
        .ccm_mode      (ccm_mode),
        .dt_peak       (dt_peak),
        .dt_valley_bcm (dt_valley_bcm),
        .dt_valley_ccm (dt_valley_ccm),
        .dt_sel        (dt_sel)
    );

    hcm_dead_timer #(
        .DT_W (DT_W)
    ) u_dead (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dt_load),
        .load_val (dt_sel),
        .expired  (gap_done)
    );

    // Next-state logic; enable low overrides every other path.
    always_comb begin
        state_nxt = state;
        dt_load   = 1'b0;
        edge_kind = EDGE_PEAK;
        if (!en) begin
            state_nxt = ST_OFF;
        end else begin
            case (state)
                ST_OFF: begin
                    state_nxt = ref_neg ? ST_FALL : ST_RISE;
                end
                ST_RISE: begin
                    if (blank_ready && cmp_peak) begin
                        state_nxt = ST_DEAD_TO_FALL;
                        dt_load   = 1'b1;
                        edge_kind = EDGE_PEAK;
                    end
                end
                ST_FALL: begin
                    edge_kind = EDGE_VALLEY;
                    if (blank_ready && cmp_valley) begin
                        state_nxt = ST_DEAD_TO_RISE;
                        dt_load   = 1'b1;
                    end
                end
                ST_DEAD_TO_FALL: begin
                    if (gap_done) state_nxt = ST_FALL;
                end
                ST_DEAD_TO_RISE: begin
                    if (gap_done) state_nxt = ST_RISE;
                end
                default: begin
                    state_nxt = ST_OFF;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // Gate decode straight from the state register.
    assign hs1_on = (state == ST_RISE);
    assign ls2_on = (state == ST_RISE);
    assign hs2_on = (state == ST_FALL);
    assign ls1_on = (state == ST_FALL);

endmodule

// File: rtl/hcm_bridge_chk.sv
// Property checker for the bridge sequencer, attached by bind. Observes
// only ports; keeps its own on-time count for the minimum-width check.
module hcm_bridge_chk #(
    parameter int MIN_ON = 143
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic ref_neg,
    input logic cmp_peak,
    input logic cmp_valley,
    input logic hs1_on,
    input logic ls1_on,
    input logic hs2_on,
    input logic ls2_on
);
    localparam int CW = $clog2(MIN_ON + 2);
    localparam logic [3:0] RISE_P = 4'b1001;
    localparam logic [3:0] FALL_P = 4'b0110;

    logic [3:0]    g;
    logic [CW-1:0] on_cnt;

    assign g = {hs1_on, ls1_on, hs2_on, ls2_on};

    // Length of the current conducting run, saturating above MIN_ON.
    always_ff @(posedge clk) begin
        if (!rst_n || g == 4'b0000) begin
            on_cnt <= '0;
        end else if (on_cnt <= CW'(MIN_ON)) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

    assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (g == 4'b0000));

    assert_legal_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (g == 4'b0000) || (g == RISE_P) || (g == FALL_P));

    assert_gap_from_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (g == RISE_P) |=> (g == RISE_P) || (g == 4'b0000));

    assert_gap_from_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (g == FALL_P) |=> (g == FALL_P) || (g == 4'b0000));

    assert_start_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !$past(en) && !ref_neg) |=> (g == RISE_P));

    assert_start_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !$past(en) && ref_neg) |=> (g == FALL_P));

    assert_rise_needs_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (g == RISE_P && en && !cmp_peak) |=> (g == RISE_P));

    assert_fall_needs_valley_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (g == FALL_P && en && !cmp_valley) |=> (g == FALL_P));

    assert_min_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (g == 4'b0000 && on_cnt != '0 && $past(en)) |-> (on_cnt >= CW'(MIN_ON)));

endmodule

bind hcm_bridge_seq hcm_bridge_chk #(.MIN_ON(MIN_ON_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .ref_neg    (ref_neg),
    .cmp_peak   (cmp_peak),
    .cmp_valley (cmp_valley),
    .hs1_on     (hs1_on),
    .ls1_on     (ls1_on),
    .hs2_on     (hs2_on),
    .ls2_on     (ls2_on)
);

// File: tb/hcm_bridge_seq_bench.sv
// Directed bench for the bridge sequencer: one task per scenario.
module hcm_bridge_seq_bench;
    localparam int         MIN_ON = 143;
    localparam logic [3:0] OFF_P  = 4'b0000;
    localparam logic [3:0] RISE_P = 4'b1001;
    localparam logic [3:0] FALL_P = 4'b0110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, ccm_mode = 1'b0, ref_neg = 1'b0;
    logic       cmp_peak = 1'b0, cmp_valley = 1'b0;
    logic [5:0] dt_peak = 6'd10, dt_valley_bcm = 6'd6, dt_valley_ccm = 6'd2;
    logic       hs1_on, ls1_on, hs2_on, ls2_on;
    logic [3:0] gates;
    int         total = 0, bad = 0, illegal = 0;

    always #2.5 clk = ~clk;

    hcm_bridge_seq u_hcm_bridge_seq (
        .clk (clk), .rst_n (rst_n), .en (en), .ccm_mode (ccm_mode),
        .ref_neg (ref_neg), .cmp_peak (cmp_peak), .cmp_valley (cmp_valley),
        .dt_peak (dt_peak), .dt_valley_bcm (dt_valley_bcm),
        .dt_valley_ccm (dt_valley_ccm),
        .hs1_on (hs1_on), .ls1_on (ls1_on), .hs2_on (hs2_on), .ls2_on (ls2_on)
    );

    assign gates = {hs1_on, ls1_on, hs2_on, ls2_on};

    // R2 monitor: record any gate pattern outside the three legal ones.
    always @(negedge clk) begin
        if (rst_n && gates != OFF_P && gates != RISE_P && gates != FALL_P)
            illegal++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_while(input logic [3:0] pat, output int n);
        n = 0;
        while (gates == pat && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_pat(input logic [3:0] pat);
        for (int i = 0; i < 5000 && gates != pat; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 gates in reset", gates, OFF_P);
        rst_n = 1'b1;
        cmp_peak = 1'b1; cmp_valley = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 gates with en low", gates, OFF_P);
        cmp_peak = 1'b0; cmp_valley = 1'b0;
    endtask

    task automatic t_bcm_cycle;
        int n;
        ccm_mode = 1'b0; ref_neg = 1'b0; cmp_peak = 1'b1; en = 1'b1;
        @(negedge clk);
        chk("R3 first pair rising", gates, RISE_P);
        count_while(RISE_P, n);
        chk("R10 held peak on-time", n, MIN_ON);
        count_while(OFF_P, n);
        chk("R5 peak gap bcm", n, 10);
        chk("R5 falling pair after gap", gates, FALL_P);
        repeat (200) @(negedge clk);
        chk("R4 peak ignored in fall", gates, FALL_P);
        cmp_valley = 1'b1;
        @(negedge clk);
        count_while(OFF_P, n);
        chk("R6 valley gap bcm", n, 6);
        chk("R6 rising pair after gap", gates, RISE_P);
        count_while(RISE_P, n);
        chk("R10 second on-time", n, MIN_ON);
    endtask

    task automatic t_ccm_cycle;
        int n;
        en = 1'b0;
        @(negedge clk);
        chk("R11 en low stops bridge", gates, OFF_P);
        ccm_mode = 1'b1; ref_neg = 1'b1; cmp_valley = 1'b1; cmp_peak = 1'b0;
        en = 1'b1;
        @(negedge clk);
        chk("R3 first pair falling", gates, FALL_P);
        count_while(FALL_P, n);
        chk("R10 held valley on-time", n, MIN_ON);
        count_while(OFF_P, n);
        chk("R7 valley gap ccm", n, 2);
        chk("R7 rising pair after gap", gates, RISE_P);
        cmp_peak = 1'b1; cmp_valley = 1'b0;
        count_while(RISE_P, n);
        count_while(OFF_P, n);
        chk("R5 peak gap ccm", n, 10);
        chk("R5 falling pair ccm", gates, FALL_P);
    endtask

    task automatic t_latch;
        int n;
        ccm_mode = 1'b0; cmp_peak = 1'b0; cmp_valley = 1'b1;
        wait_pat(OFF_P);
        ccm_mode = 1'b1; dt_valley_bcm = 6'd30; dt_valley_ccm = 6'd1;
        count_while(OFF_P, n);
        chk("R8 gap fixed at event", n, 6);
        chk("R8 rising pair after gap", gates, RISE_P);
        dt_valley_bcm = 6'd6; dt_valley_ccm = 6'd2;
    endtask

    task automatic t_zero;
        int n;
        ccm_mode = 1'b1; dt_valley_ccm = 6'd0;
        cmp_peak = 1'b1; cmp_valley = 1'b0;
        wait_pat(FALL_P);
        cmp_peak = 1'b0; cmp_valley = 1'b1;
        wait_pat(OFF_P);
        count_while(OFF_P, n);
        chk("R9 zero gap is one cycle", n, 1);
        chk("R9 rising pair after gap", gates, RISE_P);
        dt_valley_ccm = 6'd2;
    endtask

    task automatic t_priority;
        cmp_peak = 1'b0; cmp_valley = 1'b1;
        repeat (150) @(negedge clk);
        chk("R4 valley ignored in rise", gates, RISE_P);
        cmp_valley = 1'b0; cmp_peak = 1'b1; ref_neg = 1'b0; en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        chk("R11 off after en drop", gates, OFF_P);
        @(negedge clk);
        chk("R11 en beats peak event", gates, RISE_P);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_bcm_cycle();
        t_ccm_cycle();
        t_latch();
        t_zero();
        t_priority();
        chk("R2 illegal gate patterns", illegal, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule